// File: doc/BRIEF.md
# Memory-Mapped Machine Timer Comparator

This block keeps a free-running 64-bit time counter and a 64-bit compare value. It raises a level machine-timer interrupt once the counter has reached or passed the compare value. A prescaler divides the core clock down to a fixed time-base tick. For example, a division ratio of 10 turns a 100 MHz core clock into a 10 MHz tick. Each tick adds one to the counter, which wraps modulo 2^64.

Software reaches the block through a 32-bit register port with a 16-byte, little-endian window. The two 64-bit quantities cross the narrow bus with two rules. Reading the low word of time freezes the whole counter into a snapshot, and the high word is then read from that snapshot. The low word of the compare is only staged, and the full value takes effect in a single step when the high word is written. Every such commit clears the interrupt before the new value is evaluated. A value that is already due therefore re-raises the interrupt at once, and a future value keeps it low until the counter gets there.

A read request is answered in the following cycle. Only time can be read and only the compare can be written. Any other access reports an error for one cycle and has no effect on the block.

Top module: `tmc_top`

## Requirements
- R1: Reset sets the counter to the parameter TIME_RESET and the compare value to 0. During reset the read data, the error flag and the interrupt are all 0. Because a compare of 0 is due, the interrupt rises at the first clock edge after reset is released.
- R2: The counter advances by exactly one every CLK_DIV clock cycles and wraps modulo 2^64. Two time reads issued N·CLK_DIV cycles apart differ by exactly N.
- R3: A read of offset 0x0 copies the full 64-bit counter into a snapshot and returns bits 31:0 on the read data in the next cycle. In any cycle that follows no valid read, the read data is 0.
- R4: A read of offset 0x4 returns bits 63:32 of the snapshot taken at the last read of 0x0, even if the live counter has since carried into the upper word.
- R5: A write to offset 0x8 only stages 32 bits. It changes neither the active compare value nor the interrupt.
- R6: A write to offset 0xC commits {write data, staged word} as the new 64-bit compare in one step, and clears the pending interrupt first.
- R7: If the committed compare is less than or equal to the counter in the commit cycle, the interrupt is high in the next cycle.
- R8: If the committed compare is greater than the counter, the interrupt goes low. It rises one cycle after the counter first reaches the compare value, and then stays high until the next commit.
- R9: These accesses assert the error flag for exactly the following cycle with read data 0, and leave the counter, the staged word and the compare unchanged:
  - an address with bits 1:0 not zero;
  - a write to 0x0 or 0x4;
  - a read of 0x8 or 0xC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_wen | input | 1 | Write request for this cycle |
| bus_ren | input | 1 | Read request for this cycle (ignored while bus_wen is high) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| bus_err | output | 1 | One-cycle flag for an unsupported access |
| timer_irq | output | 1 | Level machine-timer interrupt |

## Verification
The checker watches the interrupt rules on every cycle:
- the counter only ever moves by one, and only after a tick;
- a staging write leaves the compare unchanged;
- a commit loads the joined value;
- a commit sets or clears the interrupt according to the comparison with the current time;
- the interrupt stays high between commits;
- an error always comes with zero read data.

Some behaviour only the bench scenarios can show:
- the exact tick rate;
- that the high word of time comes from the snapshot and not from the live counter across a 32-bit carry;
- the cycle at which a future compare fires;
- that a rejected access leaves the staged word and the counter unchanged.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned TIME_W = 2 * BUS_W;
  localparam int unsigned OFS_W  = 4;

  typedef logic [BUS_W-1:0]  word_t;
  typedef logic [TIME_W-1:0] time_t;

  typedef enum logic [2:0] {
    SEL_TIME_LO,
    SEL_TIME_HI,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_NONE
  } reg_sel_e;

  // Word-aligned offsets only; the two upper offset bits pick the register.
  function automatic reg_sel_e decode_offset(input logic [OFS_W-1:0] ofs);
    if (ofs[1:0] != 2'b00) return SEL_NONE;
    case (ofs[3:2])
      2'd0:    return SEL_TIME_LO;
      2'd1:    return SEL_TIME_HI;
      2'd2:    return SEL_CMP_LO;
      default: return SEL_CMP_HI;
    endcase
  endfunction

  function automatic time_t join_halves(input word_t hi, input word_t lo);
    return {hi, lo};
  endfunction

  function automatic time_t time_advance(input time_t t);
    return t + time_t'(1);
  endfunction

  // A compare value is due once the counter has reached or passed it.
  function automatic logic cmp_due(input time_t cmp, input time_t now);
    return cmp <= now;
  endfunction
endpackage

// File: rtl/tmc_tick_gen.sv
module tmc_tick_gen #(
  parameter int unsigned CLK_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (CLK_DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/tmc_time_base.sv
module tmc_time_base
  import tmc_pkg::*;
#(
  parameter time_t TIME_RESET = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  output time_t time_o
);
  time_t time_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      time_q <= TIME_RESET;
    else if (tick_i) time_q <= time_advance(time_q);
  end
  assign time_o = time_q;
endmodule

// File: rtl/tmc_reg_port.sv
module tmc_reg_port
  import tmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] addr_i,
  input  logic             wen_i,
  input  logic             ren_i,
  input  word_t            wdata_i,
  input  time_t            time_i,
  output word_t            rdata_o,
  output logic             err_o,
  output logic             stage_wr_o,
  output logic             commit_o,
  output time_t            commit_val_o
);
  reg_sel_e sel;
  logic     rd_req;
  logic     snap_take;
  logic     bad_acc;
  word_t    rd_val;
  word_t    stage_q;
  time_t    snap_q;
  word_t    rdata_q;
  logic     err_q;

  assign sel    = decode_offset(addr_i);
  assign rd_req = ren_i && !wen_i;

  always_comb begin
    stage_wr_o = 1'b0;
    commit_o   = 1'b0;
    snap_take  = 1'b0;
    bad_acc    = 1'b0;
    rd_val     = '0;
    if (wen_i) begin
      case (sel)
        SEL_CMP_LO: stage_wr_o = 1'b1;
        SEL_CMP_HI: commit_o   = 1'b1;
        default:    bad_acc    = 1'b1;
      endcase
    end else if (rd_req) begin
      case (sel)
        SEL_TIME_LO: begin
          snap_take = 1'b1;
          rd_val    = time_i[BUS_W-1:0];
        end
        SEL_TIME_HI: rd_val  = snap_q[TIME_W-1:BUS_W];
        default:     bad_acc = 1'b1;
      endcase
    end
  end

  assign commit_val_o = join_halves(wdata_i, stage_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      snap_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (stage_wr_o) stage_q <= wdata_i;
      if (snap_take)  snap_q  <= time_i;
      rdata_q <= rd_val;
      err_q   <= bad_acc;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/tmc_irq_unit.sv
module tmc_irq_unit
  import tmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  commit_i,
  input  time_t commit_val_i,
  input  time_t time_i,
  output time_t cmp_o,
  output logic  irq_o
);
  time_t cmp_q;
  logic  irq_q;
  logic  irq_d;

  always_comb begin
    if (commit_i) irq_d = cmp_due(commit_val_i, time_i);       // clear, then re-evaluate
    else          irq_d = irq_q | cmp_due(cmp_q, time_i);      // sticky until next commit
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (commit_i) cmp_q <= commit_val_i;
      irq_q <= irq_d;
    end
  end

  assign cmp_o = cmp_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tmc_top.sv
module tmc_top
  import tmc_pkg::*;
#(
  parameter int unsigned CLK_DIV    = 10,
  parameter time_t       TIME_RESET = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wen,
  input  logic        bus_ren,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_err,
  output logic        timer_irq
);
  logic  tick_w;
  time_t time_w;
  time_t cmp_w;
  logic  commit_w;
  time_t commit_val_w;
  logic  stage_wr_w;

  tmc_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  tmc_time_base #(.TIME_RESET(TIME_RESET)) u_time (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_w),
    .time_o (time_w)
  );

  tmc_reg_port u_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (bus_addr),
    .wen_i        (bus_wen),
    .ren_i        (bus_ren),
    .wdata_i      (bus_wdata),
    .time_i       (time_w),
    .rdata_o      (bus_rdata),
    .err_o        (bus_err),
    .stage_wr_o   (stage_wr_w),
    .commit_o     (commit_w),
    .commit_val_o (commit_val_w)
  );

  tmc_irq_unit u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_i     (commit_w),
    .commit_val_i (commit_val_w),
    .time_i       (time_w),
    .cmp_o        (cmp_w),
    .irq_o        (timer_irq)
  );
endmodule

// File: rtl/tmc_checker.sv
module tmc_checker
  import tmc_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  tick,
  input time_t time_q,
  input time_t cmp_q,
  input logic  commit,
  input time_t commit_val,
  input logic  stage_wr,
  input logic  ren,
  input logic  wen,
  input word_t rdata,
  input logic  err,
  input logic  irq
);
  a_r2_time_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && time_q != $past(time_q)) |-> (time_q == $past(time_q) + 64'd1 && $past(tick)));

  a_r3_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ren) |-> rdata == '0);

  a_r5_stage_keeps_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_wr && !commit) |=> $stable(cmp_q));

  a_r6_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> cmp_q == $past(commit_val));

  a_r7_due_commit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && commit_val <= time_q) |=> irq);

  a_r8_future_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && commit_val > time_q) |=> !irq);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !commit) |=> irq);

  a_r8_reached_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && time_q >= cmp_q) |=> irq);

  a_r9_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rdata == '0);

  a_r9_err_from_access: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(ren || wen));
endmodule

bind tmc_top tmc_checker u_tmc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick_w),
  .time_q     (time_w),
  .cmp_q      (cmp_w),
  .commit     (commit_w),
  .commit_val (commit_val_w),
  .stage_wr   (stage_wr_w),
  .ren        (bus_ren),
  .wen        (bus_wen),
  .rdata      (bus_rdata),
  .err        (bus_err),
  .irq        (timer_irq)
);

// File: tb/test_tmc_top.sv
module test_tmc_top;
  localparam int unsigned DIV = 4;
  localparam logic [63:0] T0 = 64'h0000_0000_FFFF_FF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wen = 1'b0;
  logic        ren = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tmc_top #(.CLK_DIV(DIV), .TIME_RESET(T0)) i_tmc_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen), .bus_ren(ren),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err), .timer_irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit due(input logic [63:0] cmp, input logic [63:0] now);
    return cmp <= now;
  endfunction

  // One bus access; starts and ends at a falling edge, returns the registered response.
  task automatic acc(input logic [3:0] a, input bit w, input logic [31:0] d,
                     output logic [31:0] rd, output logic e);
    addr = a; wen = w; ren = !w; wdata = d;
    @(negedge clk);
    rd = rdata; e = err;
    addr = '0; wen = 1'b0; ren = 1'b0; wdata = '0;
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    logic e;
    acc(4'h0, 1'b0, '0, lo, e);
    acc(4'h4, 1'b0, '0, hi, e);
    t = {hi, lo};
  endtask

  task automatic commit_cmp(input logic [63:0] v);
    logic [31:0] rd;
    logic e;
    acc(4'h8, 1'b1, v[31:0], rd, e);
    acc(4'hC, 1'b1, v[63:32], rd, e);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] t1, t2, cmp;
    logic [31:0] rd;
    logic e;
    int waited;
    void'($urandom(32'd20240611));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(rdata == 0 && err == 0, "R1 outputs in reset", {rdata, 31'b0, err}, 0);
    chk(irq == 0, "R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 1, "R1 irq after release with compare 0", irq, 1);
    read_time(t1);
    chk(t1 >= T0 && t1 <= T0 + 1, "R1 counter reset value", t1, T0);

    // R3/R4: snapshot survives a 32-bit carry of the live counter
    acc(4'h0, 1'b0, '0, rd, e);
    chk(rd >= 32'hFFFF_FF00, "R3 low word returned", rd, T0[31:0]);
    @(negedge clk);
    chk(rdata == 0, "R3 idle read data", rdata, 0);
    repeat (1100) @(negedge clk);
    acc(4'h4, 1'b0, '0, rd, e);
    chk(rd == 0, "R4 high word from snapshot", rd, 0);
    read_time(t1);
    chk(t1[63:32] == 1, "R4 fresh snapshot sees carry", t1[63:32], 1);

    // R2: tick rate, reads 40 cycles apart
    for (int k = 0; k < 3; k++) begin
      read_time(t1);
      repeat (38) @(negedge clk);
      read_time(t2);
      chk(t2 - t1 == 64'd10, "R2 ten ticks per 40 cycles", t2 - t1, 10);
    end

    // R6/R8: future compare clears, fires on arrival, then stays high
    read_time(t1);
    cmp = t1 + 8;
    commit_cmp(cmp);
    chk(irq == 0, "R8 future commit clears irq", irq, 0);
    waited = 0;
    while (!irq && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    chk(waited >= 20, "R8 irq not early", waited, 28);
    read_time(t2);
    chk(t2 >= cmp && t2 <= cmp + 1, "R8 irq rises on arrival", t2, cmp);
    repeat (30) @(negedge clk);
    chk(irq == 1, "R8 irq sticky", irq, 1);

    // R5: staging leaves irq and compare alone
    acc(4'h8, 1'b1, 32'hFFFF_FFFF, rd, e);
    chk(irq == 1, "R5 staging keeps irq high", irq, 1);
    read_time(t1);
    commit_cmp(t1 + 64'h1_0000_0000);
    chk(irq == 0, "R6 commit with large upper word clears", irq, 0);
    acc(4'h8, 1'b1, 32'h0, rd, e);
    repeat (10) @(negedge clk);
    chk(irq == 0, "R5 staging a past low word has no effect", irq, 0);

    // R6/R7: commit joins upper data with staged word
    commit_cmp(64'h0);
    chk(irq == 1, "R7 zero compare due immediately", irq, 1);
    read_time(t1);
    acc(4'h8, 1'b1, t1[31:0], rd, e);
    acc(4'hC, 1'b1, 32'hFFFF_0000, rd, e);
    chk(irq == 0, "R6 upper half from write data", irq, 0);

    // R7/R8: random compares around the current time
    for (int n = 0; n < 40; n++) begin
      int d;
      longint delta;
      d = int'($urandom_range(0, 38));
      delta = (d <= 20) ? -longint'(d) : longint'(d - 18);
      read_time(t1);
      cmp = t1 + 64'(delta);
      commit_cmp(cmp);
      chk(irq == due(cmp, t1), delta <= 0 ? "R7 past compare sets irq" : "R8 future compare clears irq",
          irq, due(cmp, t1));
      repeat ($urandom_range(0, 5)) @(negedge clk);
    end

    // R9: rejected accesses
    read_time(t1);
    acc(4'h0, 1'b1, 32'h0, rd, e);
    chk(e == 1 && rd == 0, "R9 time write rejected", {rd, 31'b0, e}, 1);
    acc(4'h4, 1'b1, 32'h0, rd, e);
    chk(e == 1 && rd == 0, "R9 time high write rejected", {rd, 31'b0, e}, 1);
    @(negedge clk);
    chk(err == 0, "R9 error lasts one cycle", err, 0);
    read_time(t2);
    chk(t2 >= t1 && t2 - t1 <= 3, "R9 counter untouched by time write", t2, t1);

    cmp = t2 - 4;
    acc(4'h8, 1'b1, cmp[31:0], rd, e);
    acc(4'h8, 1'b0, '0, rd, e);
    chk(e == 1 && rd == 0, "R9 compare low read rejected", {rd, 31'b0, e}, 1);
    acc(4'hC, 1'b0, '0, rd, e);
    chk(e == 1 && rd == 0, "R9 compare high read rejected", {rd, 31'b0, e}, 1);
    acc(4'h9, 1'b1, 32'hFFFF_FFFF, rd, e);
    chk(e == 1, "R9 misaligned write rejected", e, 1);
    acc(4'hE, 1'b0, '0, rd, e);
    chk(e == 1 && rd == 0, "R9 misaligned read rejected", {rd, 31'b0, e}, 1);
    acc(4'hC, 1'b1, cmp[63:32], rd, e);
    chk(e == 0, "R6 valid commit has no error", e, 0);
    chk(irq == 1, "R9 staged word kept through rejected accesses", irq, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule